// File: doc/BRIEF.md
# Paired Load/Store Sequencer

This block carries out one paired memory instruction of a RISC-V-style core. A decoded request carries a base address value, a base register index, two data register indices, a 2-bit offset field, an operation code and the two register values to be stored. The block checks whether the request is legal and derives two adjacent element addresses from it. It then runs two accesses, one after the other, on a valid/ready memory port.

For loads, both elements are collected, widened to register width, and written back together through two register-file write ports. The write happens only when both accesses succeed. For stores, the first data register's value goes to the lower address and the second register's value to the higher one. A request that fails the legality checks gets a one-cycle illegal pulse and causes no memory traffic.

Top module: `pair_mem_seq`

## Requirements
- R1: A request whose base index equals either data index, or whose two data indices are equal, is refused: `illegal_o` pulses in the cycle after the request, `busy_o` stays low and no memory request is raised.
- R2: While `ext_en_i` is low, every request is refused in the same way as R1.
- R3: Doubleword forms (codes 0 and 3) are accepted only when the register width is 64 and `mode64_i` is high; otherwise they are refused. Word forms are accepted in both modes.
- R4: With element size E (8 for doubleword, 4 for word), the offset is the 2-bit field shifted left by 4 (doubleword) or 3 (word). The first address is base + offset and the second is base + offset + E, both wrapping modulo 2^XLEN.
- R5: The first-address access is handshaken before the second is raised. A raised memory request keeps its address and direction until `mem_ready_i` is seen high at a clock edge.
- R6: Code 1 (signed word pair) sign-extends bit 31 of each returned value. Code 2 (unsigned word pair) zero-extends each value. Code 0 (doubleword pair) passes the full 64-bit value.
- R7: A successful load ends with `done_o` and `wb_en_o` high in the same cycle. Port 1 carries the first data index with the lower-address element, and port 2 carries the second data index with the higher-address element.
- R8: Stores (codes 3 and 4) drive `mem_we_o` high. The first access presents `req_wdata1_i` and the second presents `req_wdata2_i`, each as the full register value with the element in its low bits. `mem_be_o` is 8'hFF for doubleword elements and 8'h0F for word elements. Loads drive `mem_we_o` low.
- R9: `busy_o` rises on acceptance and falls when `done_o` or `err_o` pulses. Requests offered while busy are ignored, and no memory request is raised while idle.
- R10: A response with `mem_rsp_err_i` high ends the operation at once. `err_o` pulses, `done_o` and `wb_en_o` stay low, and an error on the first access means the second is never raised.
- R11: Operation codes 5, 6 and 7 are refused in the same way as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_en_i | input | 1 | Enables paired operations |
| mode64_i | input | 1 | Core currently runs in 64-bit mode |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 3 | 0 dword load, 1 signed word load, 2 unsigned word load, 3 dword store, 4 word store |
| req_rs_i | input | IDXW | Base register index |
| req_rd1_i | input | IDXW | First data register index |
| req_rd2_i | input | IDXW | Second data register index |
| req_off_i | input | 2 | Unscaled offset field |
| req_base_i | input | XLEN | Base register value |
| req_wdata1_i | input | XLEN | First data register value (stores) |
| req_wdata2_i | input | XLEN | Second data register value (stores) |
| busy_o | output | 1 | Operation in progress |
| illegal_o | output | 1 | Request refused (one-cycle pulse) |
| done_o | output | 1 | Operation completed without error (pulse) |
| err_o | output | 1 | Operation aborted by memory error (pulse) |
| mem_req_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | XLEN | Byte address |
| mem_be_o | output | 8 | Byte enables |
| mem_wdata_o | output | XLEN | Write data |
| mem_rsp_valid_i | input | 1 | Response present |
| mem_rsp_err_i | input | 1 | Response reports an error |
| mem_rdata_i | input | XLEN | Read data |
| wb_en_o | output | 1 | Write both register ports (pulse) |
| wb1_idx_o | output | IDXW | Write port 1 register index |
| wb1_data_o | output | XLEN | Write port 1 value |
| wb2_idx_o | output | IDXW | Write port 2 register index |
| wb2_data_o | output | XLEN | Write port 2 value |

## Verification
The bench builds the block with XLEN = 64 and 5-bit indices, and toggles `mode64_i`, so both the 64-bit and the word-only legality rules are reached from one instance. Every one of the eight operation codes is swept against all four offset values and two base values. One of those bases lies just below the top of the address space, which brings address wrap-around into reach. All 64 overlap combinations of three small register indices are tried. Ready delays of zero to two cycles, error responses on either access and requests offered while busy cover the handshake, abort and ignore paths.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;

    localparam logic [2:0] OP_LDP  = 3'd0;
    localparam logic [2:0] OP_LWSP = 3'd1;
    localparam logic [2:0] OP_LWUP = 3'd2;
    localparam logic [2:0] OP_SDP  = 3'd3;
    localparam logic [2:0] OP_SWP  = 3'd4;

    localparam logic [7:0] BE_DWORD = 8'hFF;
    localparam logic [7:0] BE_WORD  = 8'h0F;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISS1  = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_ISS2  = 3'd3,
        ST_WAIT2 = 3'd4
    } seq_st_e;

endpackage

// File: rtl/pair_decode.sv
module pair_decode
    import pair_seq_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IDXW = 5
) (
    input  logic [2:0]      op_i,
    input  logic [IDXW-1:0] rs_i,
    input  logic [IDXW-1:0] rd1_i,
    input  logic [IDXW-1:0] rd2_i,
    input  logic [1:0]      off_i,
    input  logic [XLEN-1:0] base_i,
    input  logic            ext_en_i,
    input  logic            mode64_i,
    output logic            legal_o,
    output logic            load_o,
    output logic            dw_o,
    output logic            sext_o,
    output logic [XLEN-1:0] addr1_o,
    output logic [XLEN-1:0] addr2_o
);

    logic            dw_ok;
    logic            known;
    logic            overlap;
    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] esize;

    generate
        if (XLEN >= 64) begin : g_wide
            assign dw_ok = mode64_i;
        end else begin : g_narrow
            logic unused_mode;
            assign unused_mode = mode64_i;
            assign dw_ok       = 1'b0;
        end
    endgenerate

    always_comb begin
        known   = (op_i <= OP_SWP);
        dw_o    = (op_i == OP_LDP) || (op_i == OP_SDP);
        load_o  = (op_i <= OP_LWUP);
        sext_o  = (op_i == OP_LWSP);
        overlap = (rs_i == rd1_i) || (rs_i == rd2_i) || (rd1_i == rd2_i);
        legal_o = ext_en_i && known && !overlap && (!dw_o || dw_ok);
        scaled  = XLEN'(off_i) << (dw_o ? 4 : 3);
        esize   = dw_o ? XLEN'(8) : XLEN'(4);
        addr1_o = base_i + scaled;
        addr2_o = addr1_o + esize;
    end

endmodule

// File: rtl/pair_extend.sv
module pair_extend #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] raw_i,
    input  logic            dw_i,
    input  logic            sext_i,
    output logic [XLEN-1:0] val_o
);

    generate
        if (XLEN > 32) begin : g_wide
            always_comb begin
                if (dw_i) begin
                    val_o = raw_i;
                end else if (sext_i) begin
                    val_o = {{(XLEN-32){raw_i[31]}}, raw_i[31:0]};
                end else begin
                    val_o = {{(XLEN-32){1'b0}}, raw_i[31:0]};
                end
            end
        end else begin : g_narrow
            logic unused_sel;
            assign unused_sel = dw_i ^ sext_i;
            assign val_o      = raw_i;
        end
    endgenerate

endmodule

// File: rtl/pair_mem_seq.sv
module pair_mem_seq
    import pair_seq_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IDXW = 5
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ext_en_i,
    input  logic            mode64_i,
    input  logic            req_valid_i,
    input  logic [2:0]      req_op_i,
    input  logic [IDXW-1:0] req_rs_i,
    input  logic [IDXW-1:0] req_rd1_i,
    input  logic [IDXW-1:0] req_rd2_i,
    input  logic [1:0]      req_off_i,
    input  logic [XLEN-1:0] req_base_i,
    input  logic [XLEN-1:0] req_wdata1_i,
    input  logic [XLEN-1:0] req_wdata2_i,
    output logic            busy_o,
    output logic            illegal_o,
    output logic            done_o,
    output logic            err_o,
    output logic            mem_req_o,
    input  logic            mem_ready_i,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [7:0]      mem_be_o,
    output logic [XLEN-1:0] mem_wdata_o,
    input  logic            mem_rsp_valid_i,
    input  logic            mem_rsp_err_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    output logic            wb_en_o,
    output logic [IDXW-1:0] wb1_idx_o,
    output logic [XLEN-1:0] wb1_data_o,
    output logic [IDXW-1:0] wb2_idx_o,
    output logic [XLEN-1:0] wb2_data_o
);

    typedef struct packed {
        seq_st_e         st;
        logic            load;
        logic            dw;
        logic            sext;
        logic [XLEN-1:0] a1;
        logic [XLEN-1:0] a2;
        logic [XLEN-1:0] w1;
        logic [XLEN-1:0] w2;
        logic [XLEN-1:0] r1;
        logic [XLEN-1:0] r2;
        logic [IDXW-1:0] i1;
        logic [IDXW-1:0] i2;
        logic            done;
        logic            err;
        logic            illegal;
        logic            wb;
    } seq_t;

    seq_t seq_d, seq_q;

    logic            dec_legal, dec_load, dec_dw, dec_sext;
    logic [XLEN-1:0] dec_a1, dec_a2;
    logic [XLEN-1:0] ext_val;

    pair_decode #(.XLEN(XLEN), .IDXW(IDXW)) decode_i (
        .op_i     (req_op_i),
        .rs_i     (req_rs_i),
        .rd1_i    (req_rd1_i),
        .rd2_i    (req_rd2_i),
        .off_i    (req_off_i),
        .base_i   (req_base_i),
        .ext_en_i (ext_en_i),
        .mode64_i (mode64_i),
        .legal_o  (dec_legal),
        .load_o   (dec_load),
        .dw_o     (dec_dw),
        .sext_o   (dec_sext),
        .addr1_o  (dec_a1),
        .addr2_o  (dec_a2)
    );

    pair_extend #(.XLEN(XLEN)) extend_i (
        .raw_i  (mem_rdata_i),
        .dw_i   (seq_q.dw),
        .sext_i (seq_q.sext),
        .val_o  (ext_val)
    );

    always_comb begin
        seq_d         = seq_q;
        seq_d.done    = 1'b0;
        seq_d.err     = 1'b0;
        seq_d.illegal = 1'b0;
        seq_d.wb      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (dec_legal) begin
                        seq_d.st   = ST_ISS1;
                        seq_d.load = dec_load;
                        seq_d.dw   = dec_dw;
                        seq_d.sext = dec_sext;
                        seq_d.a1   = dec_a1;
                        seq_d.a2   = dec_a2;
                        seq_d.w1   = req_wdata1_i;
                        seq_d.w2   = req_wdata2_i;
                        seq_d.i1   = req_rd1_i;
                        seq_d.i2   = req_rd2_i;
                    end else begin
                        seq_d.illegal = 1'b1;
                    end
                end
            end
            ST_ISS1: begin
                if (mem_ready_i) seq_d.st = ST_WAIT1;
            end
            ST_WAIT1: begin
                if (mem_rsp_valid_i) begin
                    if (mem_rsp_err_i) begin
                        seq_d.st  = ST_IDLE;
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.r1 = ext_val;
                        seq_d.st = ST_ISS2;
                    end
                end
            end
            ST_ISS2: begin
                if (mem_ready_i) seq_d.st = ST_WAIT2;
            end
            ST_WAIT2: begin
                if (mem_rsp_valid_i) begin
                    seq_d.st = ST_IDLE;
                    if (mem_rsp_err_i) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.r2   = ext_val;
                        seq_d.done = 1'b1;
                        seq_d.wb   = seq_q.load;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o      = (seq_q.st != ST_IDLE);
    assign illegal_o   = seq_q.illegal;
    assign done_o      = seq_q.done;
    assign err_o       = seq_q.err;
    assign mem_req_o   = (seq_q.st == ST_ISS1) || (seq_q.st == ST_ISS2);
    assign mem_we_o    = !seq_q.load;
    assign mem_addr_o  = (seq_q.st == ST_ISS2) ? seq_q.a2 : seq_q.a1;
    assign mem_wdata_o = (seq_q.st == ST_ISS2) ? seq_q.w2 : seq_q.w1;
    assign mem_be_o    = seq_q.dw ? BE_DWORD : BE_WORD;
    assign wb_en_o     = seq_q.wb;
    assign wb1_idx_o   = seq_q.i1;
    assign wb1_data_o  = seq_q.r1;
    assign wb2_idx_o   = seq_q.i2;
    assign wb2_data_o  = seq_q.r2;

endmodule

// File: rtl/pair_mem_seq_chk.sv
module pair_mem_seq_chk #(
    parameter int XLEN = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            busy_o,
    input logic            illegal_o,
    input logic            done_o,
    input logic            err_o,
    input logic            mem_req_o,
    input logic            mem_ready_i,
    input logic            mem_we_o,
    input logic [XLEN-1:0] mem_addr_o,
    input logic [7:0]      mem_be_o,
    input logic            wb_en_o
);

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !mem_req_o); // R9

    AST_BUSY_STARTS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> mem_req_o); // R5

    AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o || err_o) |-> !busy_o); // R9

    AST_HOLD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R5

    AST_REFUSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (!busy_o && !mem_req_o)); // R1

    AST_ERR_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !wb_en_o); // R10

    AST_BE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> (mem_be_o == 8'hFF || mem_be_o == 8'h0F)); // R8

    AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({done_o, err_o, illegal_o})); // R10

endmodule

bind pair_mem_seq pair_mem_seq_chk #(.XLEN(XLEN)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_o      (busy_o),
    .illegal_o   (illegal_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .mem_req_o   (mem_req_o),
    .mem_ready_i (mem_ready_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .wb_en_o     (wb_en_o)
);

// File: tb/pair_mem_seq_tb.sv
module pair_mem_seq_tb_top;

    localparam int XLEN = 64;
    localparam int IDXW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ext_en = 1'b1;
    logic            mode64 = 1'b1;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = '0;
    logic [IDXW-1:0] req_rs = '0, req_rd1 = '0, req_rd2 = '0;
    logic [1:0]      req_off = '0;
    logic [XLEN-1:0] req_base = '0, req_w1 = '0, req_w2 = '0;
    logic            busy, illegal, done, err;
    logic            mem_req, mem_ready = 1'b0, mem_we;
    logic [XLEN-1:0] mem_addr, mem_wdata;
    logic [7:0]      mem_be;
    logic            rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [XLEN-1:0] rdata = '0;
    logic            wb_en;
    logic [IDXW-1:0] wb1_idx, wb2_idx;
    logic [XLEN-1:0] wb1_data, wb2_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pair_mem_seq #(.XLEN(XLEN), .IDXW(IDXW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ext_en_i(ext_en), .mode64_i(mode64),
        .req_valid_i(req_valid), .req_op_i(req_op), .req_rs_i(req_rs),
        .req_rd1_i(req_rd1), .req_rd2_i(req_rd2), .req_off_i(req_off),
        .req_base_i(req_base), .req_wdata1_i(req_w1), .req_wdata2_i(req_w2),
        .busy_o(busy), .illegal_o(illegal), .done_o(done), .err_o(err),
        .mem_req_o(mem_req), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
        .mem_rsp_valid_i(rsp_valid), .mem_rsp_err_i(rsp_err), .mem_rdata_i(rdata),
        .wb_en_o(wb_en), .wb1_idx_o(wb1_idx), .wb1_data_o(wb1_data),
        .wb2_idx_o(wb2_idx), .wb2_data_o(wb2_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_pat(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A5A_F00F, a[31:0] * 32'h9E37_79B9};
    endfunction

    function automatic logic [63:0] widen(input logic [63:0] v, input logic [2:0] op);
        if (op == 3'd0) return v;
        if (op == 3'd1) return {{32{v[31]}}, v[31:0]};
        return {32'h0, v[31:0]};
    endfunction

    task automatic do_op(input logic [2:0] op, input logic [4:0] rs, input logic [4:0] rd1,
                         input logic [4:0] rd2, input logic [1:0] off, input logic [63:0] base,
                         input bit en, input bit m64, input int errsel, input int rdly,
                         input bit poke, input string rtag);
        bit          dw, ld, legal;
        logic [63:0] a[2];
        logic [63:0] w[2];
        logic [63:0] got[2];
        dw    = (op == 3'd0) || (op == 3'd3);
        ld    = (op <= 3'd2);
        legal = en && (op <= 3'd4) && (rs != rd1) && (rs != rd2) && (rd1 != rd2) && (!dw || m64);
        a[0]  = base + (dw ? 64'(off) * 64'd16 : 64'(off) * 64'd8);
        a[1]  = a[0] + (dw ? 64'd8 : 64'd4);
        w[0]  = base * 64'd5 + 64'd1;
        w[1]  = ~base ^ 64'h0123_4567_89AB_CDEF;
        @(negedge clk);
        ext_en = en; mode64 = m64;
        req_valid = 1'b1; req_op = op; req_rs = rs; req_rd1 = rd1; req_rd2 = rd2;
        req_off = off; req_base = base; req_w1 = w[0]; req_w2 = w[1];
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (!legal) begin
            check({rtag, " refused pulse"}, 64'(illegal), 64'd1);
            check({rtag, " refused stays idle"}, 64'({busy, mem_req, done}), 64'd0);
            @(posedge clk); #1;
            check({rtag, " refused no access"}, 64'(mem_req), 64'd0);
            return;
        end
        check("R9 busy after accept", 64'({busy, illegal}), 64'b10);
        for (int k = 0; k < 2; k++) begin
            check(k == 0 ? "R4 R5 first address" : "R4 R5 second address", mem_addr, a[k]);
            check("R8 direction", 64'(mem_we), 64'(!ld));
            check("R8 byte enables", 64'(mem_be), dw ? 64'hFF : 64'h0F);
            if (!ld) check("R8 store data", mem_wdata, w[k]);
            for (int d = 0; d < rdly; d++) begin
                if (poke && k == 0 && d == 0) begin
                    req_valid = 1'b1; req_op = 3'd4; req_rs = 5'd9; req_rd1 = 5'd10;
                    req_rd2 = 5'd11; req_base = base + 64'h1000; req_off = ~off;
                end
                @(posedge clk); #1;
                req_valid = 1'b0;
                check("R5 R9 request held", {mem_req, mem_addr[62:0]}, {1'b1, a[k][62:0]});
            end
            mem_ready = 1'b1;
            @(posedge clk); #1;
            mem_ready = 1'b0;
            check("R5 request dropped after handshake", 64'(mem_req), 64'd0);
            rsp_valid = 1'b1;
            rsp_err   = (errsel == k + 1);
            rdata     = mem_pat(a[k]);
            got[k]    = widen(rdata, op);
            @(posedge clk); #1;
            rsp_valid = 1'b0; rsp_err = 1'b0;
            if (errsel == k + 1) begin
                check("R10 error pulse", 64'({err, done, wb_en, busy}), 64'b1000);
                @(posedge clk); #1;
                check("R10 no further access", 64'(mem_req), 64'd0);
                return;
            end
        end
        check("R7 R9 completion", 64'({done, err, busy}), 64'b100);
        check("R7 writeback enable", 64'(wb_en), 64'(ld));
        if (ld) begin
            check("R7 port1 index", 64'(wb1_idx), 64'(rd1));
            check("R7 port2 index", 64'(wb2_idx), 64'(rd2));
            check("R6 R7 port1 value", wb1_data, got[0]);
            check("R6 R7 port2 value", wb2_data, got[1]);
        end
        @(posedge clk); #1;
        check("R9 no access after completion", 64'({mem_req, busy}), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset state", 64'({busy, mem_req, done, err, illegal, wb_en}), 64'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R9 idle after reset", 64'({busy, mem_req}), 64'd0);

        // R3 R4 R6 R7 R8 R11: all codes, offsets, both modes, normal and wrapping bases
        for (int m = 0; m < 2; m++)
            for (int op = 0; op < 8; op++)
                for (int off = 0; off < 4; off++)
                    for (int b = 0; b < 2; b++)
                        do_op(3'(op), 5'd1, 5'd2, 5'd3, 2'(off),
                              b ? 64'hFFFF_FFFF_FFFF_FFF0 : 64'h0000_0000_8000_1000 + 64'(op * 64),
                              1'b1, m[0], 0, (op + off) % 3, 1'b0,
                              op > 4 ? "R11 bad code" : "R3 dword outside 64-bit mode");

        // R1: register overlap sweep
        for (int s = 0; s < 4; s++)
            for (int x = 0; x < 4; x++)
                for (int y = 0; y < 4; y++)
                    do_op(3'd1, 5'(s), 5'(x), 5'(y), 2'(s), 64'h0000_0000_0000_4000,
                          1'b1, 1'b1, 0, 0, 1'b0, "R1 overlap");

        // R2: extension disabled
        for (int op = 0; op < 5; op++)
            do_op(3'(op), 5'd4, 5'd5, 5'd6, 2'd1, 64'h2000, 1'b0, 1'b1, 0, 0, 1'b0, "R2 disabled");

        // R10: errors on either access, loads and stores
        for (int op = 0; op < 5; op++)
            for (int e = 1; e < 3; e++)
                do_op(3'(op), 5'd7, 5'd8, 5'd12, 2'd2, 64'h0000_0010_0000_0000,
                      1'b1, 1'b1, e, 1, 1'b0, "R10 unexpected refuse");

        // R9: request offered while busy is ignored
        for (int op = 0; op < 5; op++)
            do_op(3'(op), 5'd13, 5'd14, 5'd15, 2'd3, 64'h0000_0000_1234_5670,
                  1'b1, 1'b1, 0, 2, 1'b1, "R9 unexpected refuse");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule